// File: doc/BRIEF.md
# IDE DMA transfer sequencer

The sequencer sits between a descriptor-driven DMA channel and a drive model. A transfer begins with a start pulse that carries the drive's parameters: whether it is a disk or a packet device, the command, the sector number and sector count for a disk, and the block address and transfer size for a packet device. From then on the block keeps two running values: a signed count of bytes still owed and a byte index into the transfer. Both carry over from one descriptor buffer to the next, so a single transfer can be spread across any number of buffers.

For each buffer that the channel presents, the block issues one storage request. The request holds a byte offset on the medium, the buffer's memory address, a length and a direction. The block acknowledges the buffer when the storage side reports completion. When the owed count reaches zero or goes negative, the transfer ends with a done pulse. A disk also gets ready/seek-complete status and a raised drive interrupt. A packet device with an all-ones block address is treated as a one-shot copy. A storage error ends the transfer with an error flag. A buffer that arrives while no transfer is armed is held back until the next start.

Top module: `ide_dma_seq`

## Requirements
- R1: A start pulse is taken only while no transfer is armed. It clears the byte index, the status, the drive interrupt and the error flag. It loads the owed count with sector count × 512 for a disk, or with the packet transfer size for a packet device. A start pulse during an armed transfer is ignored.
- R2: For a disk, a request has offset = sector number × 512 + byte index. Its address is the buffer address and its length is the buffer length L.
- R3: For a packet device, a request has offset = block address × 2048 + byte index, and its direction is always 0 (device to memory).
- R4: Each buffer of non-zero length L produces exactly one single-cycle request. The buffer is acknowledged (descAck) in the cycle the storage side reports completion. The byte index grows by L and the owed count shrinks by L.
- R5: A buffer of length 0 is acknowledged without a request and without ending the transfer.
- R6: A transfer ends when the owed count is ≤ 0, either at completion of the request that made it so or when a buffer arrives while the count is already ≤ 0. A buffer that arrives in that case is acknowledged with no request. The end gives one single-cycle donePulse. For a disk it also sets statusOut to 8'h50 and sets driveIrq to 1.
- R7: At the end of a packet-device transfer, statusOut stays 8'h00 and driveIrq stays 0.
- R8: A buffer presented while no transfer is armed raises descParked and is neither acknowledged nor turned into a request. It is serviced after the next start.
- R9: For a packet device whose block address is all ones, the first non-empty buffer gives one request of length min(owed count, L) at offset equal to the byte index (0). The transfer then ends at completion of that request.
- R10: A completion with stgErr set raises errFlag and acknowledges the buffer. It gives no donePulse, disarms the transfer, and no further request follows.
- R11: For a disk, the command selects the direction: 2'd0 (read) gives reqDir 0, and 2'd1 (write) and 2'd2 (trim) give reqDir 1 (memory to device).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startValid | input | 1 | Start pulse for a new transfer |
| startIsPkt | input | 1 | 1 = packet device, 0 = disk |
| startCmd | input | 2 | 0 read, 1 write, 2 trim |
| startSector | input | 32 | Disk sector number |
| startCount | input | 16 | Disk sector count |
| startLba | input | 32 | Packet-device block address |
| startPktSize | input | 32 | Packet-device transfer size in bytes |
| descValid | input | 1 | A buffer is presented |
| descAddr | input | 32 | Buffer memory address |
| descLen | input | 32 | Buffer length in bytes |
| descAck | output | 1 | Buffer service finished; consumed at this edge |
| descParked | output | 1 | Buffer held because no transfer is armed |
| reqValid | output | 1 | Storage request pulse |
| reqOffset | output | 48 | Byte offset on the medium |
| reqAddr | output | 32 | Memory address of the request |
| reqLen | output | 32 | Request length in bytes |
| reqDir | output | 1 | 0 device to memory, 1 memory to device |
| stgDone | input | 1 | Storage request completed |
| stgErr | input | 1 | Completion carries an error |
| donePulse | output | 1 | Transfer finished successfully |
| errFlag | output | 1 | Transfer aborted by a storage error |
| statusOut | output | 8 | Drive status |
| driveIrq | output | 1 | Drive interrupt level |

## Verification
The interaction most likely to be mishandled is a start pulse that lands in the same cycle as a buffer that is already parked. The start must arm the block, and the parked buffer must then be serviced with the offsets of the new transfer rather than lost or served twice. The bench first holds a buffer against the idle block and confirms descParked with no request. It then raises start on that same cycle. The scoreboard demands exactly one request with the new sector's offset, followed by an ending. Ending at completion versus ending on arrival, with the owed count exact or negative, is also provoked and judged through donePulse and status.

// File: rtl/ide_dma_pkg.sv
package ide_dma_pkg;
  localparam int SECT_SHIFT = 9;
  localparam int PKT_SHIFT  = 11;
  localparam logic [7:0] STAT_READY_SEEK = 8'h50;

  typedef enum logic [1:0] {
    CMD_READ  = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_TRIM  = 2'd2
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_BUSY
  } state_e;

  typedef struct packed {
    logic load;
    logic issue;
    logic finish;
    logic fail;
  } strobe_t;
endpackage

// File: rtl/ide_dma_ctrl.sv
module ide_dma_ctrl
  import ide_dma_pkg::*;
#(
  parameter int LEN_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic             descValid,
  input  logic [LEN_W-1:0] descLen,
  input  logic             stgDone,
  input  logic             stgErr,
  input  logic             remNonPos,
  input  logic             copyMode,
  output strobe_t          strb,
  output logic             descAck,
  output logic             descParked
);
  state_e state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    strb    = '0;
    descAck = 1'b0;
    nxt     = state;
    unique case (state)
      ST_IDLE: begin
        if (startValid) begin
          strb.load = 1'b1;
          nxt       = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (descValid) begin
          if (remNonPos) begin
            strb.finish = 1'b1;
            descAck     = 1'b1;
            nxt         = ST_IDLE;
          end else if (descLen == '0) begin
            descAck = 1'b1;
          end else begin
            strb.issue = 1'b1;
            nxt        = ST_BUSY;
          end
        end
      end
      ST_BUSY: begin
        if (stgDone) begin
          descAck = 1'b1;
          if (stgErr) begin
            strb.fail = 1'b1;
            nxt       = ST_IDLE;
          end else if (copyMode || remNonPos) begin
            strb.finish = 1'b1;
            nxt         = ST_IDLE;
          end else begin
            nxt = ST_WAIT;
          end
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign descParked = descValid && (state == ST_IDLE);
endmodule

// File: rtl/ide_dma_dp.sv
module ide_dma_dp
  import ide_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 32,
  parameter int CNT_W  = 16,
  parameter int BLK_W  = 32,
  parameter int OFS_W  = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              startIsPkt,
  input  logic [1:0]        startCmd,
  input  logic [BLK_W-1:0]  startSector,
  input  logic [CNT_W-1:0]  startCount,
  input  logic [BLK_W-1:0]  startLba,
  input  logic [LEN_W-1:0]  startPktSize,
  input  logic [ADDR_W-1:0] descAddr,
  input  logic [LEN_W-1:0]  descLen,
  output logic              remNonPos,
  output logic              copyMode,
  output logic              reqValid,
  output logic [OFS_W-1:0]  reqOffset,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [LEN_W-1:0]  reqLen,
  output logic              reqDir,
  output logic              donePulse,
  output logic              errFlag,
  output logic [7:0]        statusOut,
  output logic              driveIrq
);
  logic signed [LEN_W-1:0] remaining;
  logic [LEN_W-1:0]        byteIdx;
  logic [BLK_W-1:0]        sectorR, lbaR;
  logic                    isPktR;
  logic [1:0]              cmdR;
  logic [LEN_W-1:0]        issueLen, remU;
  logic [OFS_W-1:0]        baseOfs;

  assign remNonPos = (remaining <= 0);
  assign remU      = LEN_W'(remaining);
  assign issueLen  = (copyMode && (remU < descLen)) ? remU : descLen;
  assign baseOfs   = isPktR ? (OFS_W'(lbaR) << PKT_SHIFT)
                            : (OFS_W'(sectorR) << SECT_SHIFT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remaining <= '0;
      byteIdx   <= '0;
      sectorR   <= '0;
      lbaR      <= '0;
      isPktR    <= 1'b0;
      cmdR      <= CMD_READ;
      copyMode  <= 1'b0;
      reqValid  <= 1'b0;
      reqOffset <= '0;
      reqAddr   <= '0;
      reqLen    <= '0;
      reqDir    <= 1'b0;
      donePulse <= 1'b0;
      errFlag   <= 1'b0;
      statusOut <= '0;
      driveIrq  <= 1'b0;
    end else begin
      reqValid  <= 1'b0;
      donePulse <= 1'b0;
      if (strb.load) begin
        remaining <= startIsPkt ? startPktSize
                                : (LEN_W'(startCount) << SECT_SHIFT);
        byteIdx   <= '0;
        sectorR   <= startSector;
        lbaR      <= startLba;
        isPktR    <= startIsPkt;
        cmdR      <= startCmd;
        copyMode  <= startIsPkt && (&startLba);
        errFlag   <= 1'b0;
        statusOut <= '0;
        driveIrq  <= 1'b0;
      end
      if (strb.issue) begin
        reqValid  <= 1'b1;
        reqAddr   <= descAddr;
        reqLen    <= issueLen;
        reqOffset <= copyMode ? OFS_W'(byteIdx) : baseOfs + OFS_W'(byteIdx);
        reqDir    <= !isPktR && (cmdR == CMD_WRITE || cmdR == CMD_TRIM);
        remaining <= remaining - $signed(issueLen);
        byteIdx   <= byteIdx + issueLen;
      end
      if (strb.finish) begin
        donePulse <= 1'b1;
        if (!isPktR) begin
          statusOut <= STAT_READY_SEEK;
          driveIrq  <= 1'b1;
        end
      end
      if (strb.fail) errFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/ide_dma_seq.sv
module ide_dma_seq
  import ide_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 32,
  parameter int CNT_W  = 16,
  parameter int BLK_W  = 32,
  parameter int OFS_W  = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic              startIsPkt,
  input  logic [1:0]        startCmd,
  input  logic [BLK_W-1:0]  startSector,
  input  logic [CNT_W-1:0]  startCount,
  input  logic [BLK_W-1:0]  startLba,
  input  logic [LEN_W-1:0]  startPktSize,
  input  logic              descValid,
  input  logic [ADDR_W-1:0] descAddr,
  input  logic [LEN_W-1:0]  descLen,
  output logic              descAck,
  output logic              descParked,
  output logic              reqValid,
  output logic [OFS_W-1:0]  reqOffset,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [LEN_W-1:0]  reqLen,
  output logic              reqDir,
  input  logic              stgDone,
  input  logic              stgErr,
  output logic              donePulse,
  output logic              errFlag,
  output logic [7:0]        statusOut,
  output logic              driveIrq
);
  strobe_t strb;
  logic    remNonPos, copyMode;

  ide_dma_ctrl #(.LEN_W(LEN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .descValid(descValid),
    .descLen(descLen), .stgDone(stgDone), .stgErr(stgErr),
    .remNonPos(remNonPos), .copyMode(copyMode), .strb(strb),
    .descAck(descAck), .descParked(descParked)
  );

  ide_dma_dp #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W),
               .BLK_W(BLK_W), .OFS_W(OFS_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .startIsPkt(startIsPkt),
    .startCmd(startCmd), .startSector(startSector), .startCount(startCount),
    .startLba(startLba), .startPktSize(startPktSize), .descAddr(descAddr),
    .descLen(descLen), .remNonPos(remNonPos), .copyMode(copyMode),
    .reqValid(reqValid), .reqOffset(reqOffset), .reqAddr(reqAddr),
    .reqLen(reqLen), .reqDir(reqDir), .donePulse(donePulse),
    .errFlag(errFlag), .statusOut(statusOut), .driveIrq(driveIrq)
  );
endmodule

// File: rtl/ide_dma_chk.sv
module ide_dma_chk (
  input logic       clk,
  input logic       rstN,
  input logic       descParked,
  input logic       reqValid,
  input logic       donePulse,
  input logic       errFlag,
  input logic [7:0] statusOut,
  input logic       driveIrq
);
  AST_PARK_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    descParked |=> !reqValid);                              // R8
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> !reqValid);                                // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);                              // R6
  AST_DISK_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (donePulse && driveIrq) |-> statusOut == 8'h50);        // R6
  AST_ERR_NO_DONE: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !donePulse);                                // R10
  AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !reqValid);                                 // R10
endmodule

bind ide_dma_seq ide_dma_chk u_chk (
  .clk(clk), .rstN(rstN), .descParked(descParked), .reqValid(reqValid),
  .donePulse(donePulse), .errFlag(errFlag), .statusOut(statusOut),
  .driveIrq(driveIrq)
);

// File: tb/sim_ide_dma_seq.sv
module sim_ide_dma_seq;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN = 1'b0;
  logic        startValid = 0, startIsPkt = 0;
  logic [1:0]  startCmd = 0;
  logic [31:0] startSector = 0, startLba = 0, startPktSize = 0;
  logic [15:0] startCount = 0;
  logic        descValid = 0;
  logic [31:0] descAddr = 0, descLen = 0;
  logic        descAck, descParked, reqValid, reqDir;
  logic [47:0] reqOffset;
  logic [31:0] reqAddr, reqLen;
  logic        stgDone = 0, stgErr = 0, errInj = 0;
  logic        donePulse, errFlag, driveIrq;
  logic [7:0]  statusOut;

  ide_dma_seq u0 (.*);

  typedef struct {
    longint ofs; longint addr; longint len; bit dir; string tag;
  } exp_t;
  exp_t expQ[$];
  int nChecks = 0, nErr = 0, doneCnt = 0;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic pushExp(longint ofs, longint addr, longint len, bit dir, string tag);
    exp_t e;
    e.ofs = ofs; e.addr = addr; e.len = len; e.dir = dir; e.tag = tag;
    expQ.push_back(e);
  endtask

  // monitor: compare requests against the scoreboard
  always @(negedge clk) begin
    if (rstN && reqValid) begin
      if (expQ.size() == 0) begin
        check(0, "R4", "unexpected request offset", longint'(reqOffset), -1);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(reqOffset == 48'(e.ofs), e.tag, "offset", longint'(reqOffset), e.ofs);
        check(reqAddr == 32'(e.addr), e.tag, "addr", longint'(reqAddr), e.addr);
        check(reqLen == 32'(e.len), e.tag, "len", longint'(reqLen), e.len);
        check(reqDir == e.dir, e.tag, "dir", longint'(reqDir), longint'(e.dir));
      end
    end
    if (rstN && donePulse) doneCnt++;
  end

  // storage model: completes each request two cycles later
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && reqValid) begin
        repeat (2) @(negedge clk);
        stgDone = 1'b1;
        stgErr  = errInj;
        @(negedge clk);
        stgDone = 1'b0;
        stgErr  = 1'b0;
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nErr++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  task automatic doStart(bit pkt, logic [1:0] cmd, int sector, int count, int lba, int psize);
    startIsPkt = pkt; startCmd = cmd; startSector = sector; startCount = 16'(count);
    startLba = lba; startPktSize = psize; startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
  endtask

  task automatic sendDesc(int addr, int len);
    @(negedge clk);
    descAddr = addr; descLen = len; descValid = 1'b1;
    #1;
    while (!descAck) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    descValid = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(reqValid == 0, "R1", "reset reqValid", longint'(reqValid), 0);
    check(donePulse == 0 && errFlag == 0, "R1", "reset done/err", longint'({donePulse, errFlag}), 0);
    check(statusOut == 0 && driveIrq == 0, "R1", "reset status/irq", longint'({statusOut, driveIrq}), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 R11: disk read across two buffers, index carried
    @(negedge clk); doStart(0, 2'd0, 100, 2, 0, 0);
    pushExp(51200, 'h1000, 512, 0, "R2");
    pushExp(51712, 'h2000, 512, 0, "R4");
    sendDesc('h1000, 512);
    sendDesc('h2000, 512);
    settle();
    check(doneCnt == 1, "R6", "done after exact count", doneCnt, 1);
    check(statusOut == 8'h50, "R6", "disk status", longint'(statusOut), 'h50);
    check(driveIrq == 1, "R6", "disk irq", longint'(driveIrq), 1);

    // R5: zero-length buffer; R6 negative remainder; R11 write
    @(negedge clk); doStart(0, 2'd1, 3, 1, 0, 0);
    @(negedge clk);
    check(statusOut == 0 && driveIrq == 0, "R1", "start clears status", longint'(statusOut), 0);
    sendDesc('h4000, 0);
    settle();
    check(doneCnt == 1, "R5", "no end on empty buffer", doneCnt, 1);
    pushExp(1536, 'h5000, 1024, 1, "R11");
    sendDesc('h5000, 1024);
    settle();
    check(doneCnt == 2, "R6", "done after negative remainder", doneCnt, 2);

    // R6: buffer arriving with nothing owed ends without request
    @(negedge clk); doStart(0, 2'd0, 9, 0, 0, 0);
    sendDesc('h6000, 512);
    settle();
    check(doneCnt == 3, "R6", "done on arrival", doneCnt, 3);
    check(statusOut == 8'h50, "R6", "status on arrival end", longint'(statusOut), 'h50);

    // R11: trim direction
    @(negedge clk); doStart(0, 2'd2, 7, 1, 0, 0);
    pushExp(3584, 'h7000, 512, 1, "R11");
    sendDesc('h7000, 512);
    settle();
    check(doneCnt == 4, "R11", "trim done", doneCnt, 4);

    // R3 R7: packet transfer, command write still reads
    @(negedge clk); doStart(1, 2'd1, 0, 0, 5, 4096);
    pushExp(10240, 'h8000, 2048, 0, "R3");
    pushExp(12288, 'h9000, 2048, 0, "R3");
    sendDesc('h8000, 2048);
    sendDesc('h9000, 2048);
    settle();
    check(doneCnt == 5, "R7", "packet done", doneCnt, 5);
    check(statusOut == 0 && driveIrq == 0, "R7", "packet status untouched", longint'({statusOut, driveIrq}), 0);

    // R9: one-shot copy, both min choices
    @(negedge clk); doStart(1, 2'd0, 0, 0, -1, 100);
    pushExp(0, 'hA000, 100, 0, "R9");
    sendDesc('hA000, 512);
    settle();
    check(doneCnt == 6, "R9", "copy done short size", doneCnt, 6);
    @(negedge clk); doStart(1, 2'd0, 0, 0, -1, 600);
    pushExp(0, 'hB000, 256, 0, "R9");
    sendDesc('hB000, 256);
    settle();
    check(doneCnt == 7, "R9", "copy done short buffer", doneCnt, 7);

    // R8: parked buffer, then start in the same cycle
    @(negedge clk);
    descAddr = 'hC000; descLen = 512; descValid = 1'b1;
    settle();
    check(descParked == 1, "R8", "parked while idle", longint'(descParked), 1);
    check(descAck == 0, "R8", "no ack while parked", longint'(descAck), 0);
    pushExp(4096, 'hC000, 512, 0, "R8");
    doStart(0, 2'd0, 8, 1, 0, 0);
    #1;
    while (!descAck) begin @(negedge clk); #1; end
    @(negedge clk); descValid = 1'b0;
    settle();
    check(doneCnt == 8, "R8", "parked buffer serviced", doneCnt, 8);

    // R1: start ignored while armed
    @(negedge clk); doStart(0, 2'd0, 0, 1, 0, 0);
    @(negedge clk); doStart(0, 2'd0, 50, 4, 0, 0);
    pushExp(0, 'hD000, 512, 0, "R1");
    sendDesc('hD000, 512);
    settle();
    check(doneCnt == 9, "R1", "second start ignored", doneCnt, 9);

    // R10: storage error
    @(negedge clk); doStart(0, 2'd0, 2, 2, 0, 0);
    errInj = 1'b1;
    pushExp(1024, 'hE000, 512, 0, "R10");
    sendDesc('hE000, 512);
    errInj = 1'b0;
    settle();
    check(errFlag == 1, "R10", "error flag", longint'(errFlag), 1);
    check(doneCnt == 9, "R10", "no done on error", doneCnt, 9);
    @(negedge clk);
    descAddr = 'hF000; descLen = 512; descValid = 1'b1;
    settle();
    check(descParked == 1, "R10", "disarmed after error", longint'(descParked), 1);
    descValid = 1'b0;
    @(negedge clk); doStart(0, 2'd0, 0, 1, 0, 0);
    @(negedge clk);
    check(errFlag == 0, "R1", "start clears error", longint'(errFlag), 0);
    pushExp(0, 'h1100, 512, 0, "R1");
    sendDesc('h1100, 512);
    settle();

    check(expQ.size() == 0, "R4", "missing requests", expQ.size(), 0);
    summary();
    $finish;
  end
endmodule